// File: doc/BRIEF.md
# Graceful Stop and Interrupt Aggregator

This block sits beside a network DMA engine and owns three things: the graceful stop handshake for each direction, the event and mask registers, and the three interrupt lines (transmit, receive, error). Software asks for a stop by writing the DMA control word. If the direction is idle, the stop completes in the same write. If a frame is moving, the stop waits until that frame's end-of-frame strobe. In both cases completion sets a stop-complete event, and that event raises the error interrupt when its mask bit allows it.

The block also drives a periodic poll request for transmit ring 0. Writing the control word with the wait-on-poll bit clear starts or restarts the poll timer. A tick issues a request only while wait-on-poll is clear and no transmit stop is held. The data path posts other events through a set-strobe vector. Software clears events by writing ones. Each interrupt line drops only when every event of its group has been cleared.

Each stop direction runs one state machine (`gsi_stop_fsm`) with three states:
- STOP_RUN: no stop held.
- STOP_DRAIN: stop requested, waiting for end of frame.
- STOP_HALTED: stop completed.

Its transitions are:
- A write with the stop bit set while idle goes to STOP_HALTED and pulses completion.
- A write with the stop bit set while busy goes to STOP_DRAIN.
- In STOP_DRAIN, an end-of-frame strobe goes to STOP_HALTED and pulses completion.
- A write with the stop bit clear returns to STOP_RUN from any state.

The poll timer (`gsi_poll_timer`) has two states, POLL_IDLE and POLL_COUNT:
- A control write with wait-on-poll clear enters POLL_COUNT and reloads the counter.
- At terminal count the timer rearms while wait-on-poll is clear. Otherwise it returns to POLL_IDLE.

Top module: `stop_irq_agg`

## Requirements
- R1: After reset the event vector reads zero, all three interrupt lines are low and no poll request is issued.
- R2: A control write with the receive stop bit set while rx_busy is low sets event bit GRSC_BIT (default 3) visible in the next cycle. If mask bit GRSC_BIT is set, irq_err goes high in that same cycle.
- R3: A control write with the transmit stop bit set while tx_busy is low sets event bit GTSC_BIT (default 2) in the next cycle. If mask bit GTSC_BIT is set, irq_err goes high in that same cycle.
- R4: A stop requested while its direction is busy leaves the stop-complete event clear until the end-of-frame strobe. The event appears in the cycle after that strobe.
- R5: A stop-complete event whose mask bit is clear is recorded in the event vector but does not raise irq_err.
- R6: Writing ones through the clear port clears those event bits. A set strobe for a bit wins over a clear of that bit in the same cycle.
- R7: irq_tx follows event bit TXF_BIT (default 0) and irq_rx follows event bit RXF_BIT (default 1). Each rises when its event is set with the mask bit set, and falls only once that event is cleared.
- R8: irq_err stays high while any event bit inside ERR_GROUP (default bits 2 to 24) is set, and falls once all of them are clear.
- R9: After a control write with wait-on-poll and transmit stop both clear, poll_req pulses for one cycle every TICK_CYCLES cycles. The first pulse comes in the TICK_CYCLES-th cycle after the write.
- R10: No poll request is issued while the held wait-on-poll bit or the held transmit stop bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_wr | input | 1 | Write strobe for the DMA control word |
| dma_grs | input | 1 | Receive graceful stop bit of the written word |
| dma_gts | input | 1 | Transmit graceful stop bit of the written word |
| dma_wop | input | 1 | Wait-on-poll bit of the written word |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_data | input | EVW | New mask value |
| ev_clr_wr | input | 1 | Write strobe for the event register (write-one-to-clear) |
| ev_clr_data | input | EVW | Event bits to clear |
| ev_set | input | EVW | Event set strobes from the data path |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| event_q | output | EVW | Event register contents |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |
| poll_req | output | 1 | Poll request for transmit ring 0 |

## Verification
Several relations are checked on every cycle:
- Each interrupt line implies that an event of its group is set.
- A set strobe is always visible in the event vector one cycle later.
- An idle receive stop always completes in the next cycle.
- A poll request never follows a wait-on-poll write and never lasts two cycles.

Other properties can be seen only through the bench's scenarios:
- The deferral of a busy stop until end of frame.
- Masking that leaves an event recorded without raising an interrupt.
- The exact poll period.
- Suppression of polling by a held transmit stop.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
    typedef enum logic [1:0] {
        STOP_RUN    = 2'd0,
        STOP_DRAIN  = 2'd1,
        STOP_HALTED = 2'd2
    } stop_st_e;

    typedef enum logic {
        POLL_IDLE  = 1'b0,
        POLL_COUNT = 1'b1
    } poll_st_e;
endpackage

// File: rtl/gsi_stop_fsm.sv
module gsi_stop_fsm
    import gsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_bit,
    input  logic busy,
    input  logic eof,
    output logic done
);
    stop_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STOP_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (req_wr) begin
            if (!req_bit) begin
                st_d = STOP_RUN;
            end else if (busy) begin
                st_d = STOP_DRAIN;
            end else begin
                st_d = STOP_HALTED;
                done = 1'b1;
            end
        end else begin
            unique case (st_q)
                STOP_RUN:    st_d = STOP_RUN;
                STOP_DRAIN: begin
                    if (eof) begin
                        st_d = STOP_HALTED;
                        done = 1'b1;
                    end
                end
                STOP_HALTED: st_d = STOP_HALTED;
                default:     st_d = STOP_RUN;
            endcase
        end
    end
endmodule

// File: rtl/gsi_poll_timer.sv
module gsi_poll_timer
    import gsi_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wop_q,
    input  logic gts_q,
    output logic poll_req
);
    localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TICK_CYCLES - 1);

    poll_st_e       st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           expire;

    assign expire = (st_q == POLL_COUNT) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= POLL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start) begin
            st_d  = POLL_COUNT;
            cnt_d = RELOAD;
        end else begin
            unique case (st_q)
                POLL_IDLE: st_d = POLL_IDLE;
                POLL_COUNT: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (!wop_q) begin
                        cnt_d = RELOAD;
                    end else begin
                        st_d = POLL_IDLE;
                    end
                end
                default: st_d = POLL_IDLE;
            endcase
        end
    end

    always_comb begin
        poll_req = expire && !wop_q && !gts_q;
    end
endmodule

// File: rtl/gsi_event_reg.sv
module gsi_event_reg #(
    parameter int unsigned     EVW       = 32,
    parameter int unsigned     TXF_BIT   = 0,
    parameter int unsigned     RXF_BIT   = 1,
    parameter logic [EVW-1:0]  ERR_GROUP = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] set_vec,
    input  logic           clr_wr,
    input  logic [EVW-1:0] clr_data,
    input  logic [EVW-1:0] mask_q,
    output logic [EVW-1:0] event_q,
    output logic           irq_tx,
    output logic           irq_rx,
    output logic           irq_err
);
    logic [EVW-1:0] ev_d;
    logic           tx_d, rx_d, err_d;

    always_comb begin
        ev_d = event_q;
        if (clr_wr) ev_d = ev_d & ~clr_data;
        ev_d = ev_d | set_vec;

        tx_d  = irq_tx;
        rx_d  = irq_rx;
        err_d = irq_err;
        if (!ev_d[TXF_BIT]) tx_d = 1'b0;
        if (!ev_d[RXF_BIT]) rx_d = 1'b0;
        if ((ev_d & ERR_GROUP) == '0) err_d = 1'b0;
        if (set_vec[TXF_BIT] && mask_q[TXF_BIT]) tx_d = 1'b1;
        if (set_vec[RXF_BIT] && mask_q[RXF_BIT]) rx_d = 1'b1;
        if ((set_vec & ERR_GROUP & mask_q) != '0) err_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= '0;
            irq_tx  <= 1'b0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            event_q <= ev_d;
            irq_tx  <= tx_d;
            irq_rx  <= rx_d;
            irq_err <= err_d;
        end
    end
endmodule

// File: rtl/stop_irq_agg.sv
module stop_irq_agg #(
    parameter int unsigned     EVW         = 32,
    parameter int unsigned     TXF_BIT     = 0,
    parameter int unsigned     RXF_BIT     = 1,
    parameter int unsigned     GTSC_BIT    = 2,
    parameter int unsigned     GRSC_BIT    = 3,
    parameter logic [EVW-1:0]  ERR_GROUP   = EVW'(32'h01FF_FFFC),
    parameter int unsigned     TICK_CYCLES = 1_000_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dma_wr,
    input  logic           dma_grs,
    input  logic           dma_gts,
    input  logic           dma_wop,
    input  logic           mask_wr,
    input  logic [EVW-1:0] mask_data,
    input  logic           ev_clr_wr,
    input  logic [EVW-1:0] ev_clr_data,
    input  logic [EVW-1:0] ev_set,
    input  logic           tx_busy,
    input  logic           rx_busy,
    input  logic           tx_eof,
    input  logic           rx_eof,
    output logic [EVW-1:0] event_q,
    output logic           irq_tx,
    output logic           irq_rx,
    output logic           irq_err,
    output logic           poll_req
);
    localparam int unsigned NDIR = 2;

    logic            gts_q, wop_q;
    logic [EVW-1:0]  mask_q;
    logic [EVW-1:0]  set_vec;
    logic [NDIR-1:0] dir_bit, dir_busy, dir_eof, dir_done;

    assign dir_bit  = {dma_grs, dma_gts};
    assign dir_busy = {rx_busy, tx_busy};
    assign dir_eof  = {rx_eof, tx_eof};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gts_q  <= 1'b0;
            wop_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (dma_wr) begin
                gts_q <= dma_gts;
                wop_q <= dma_wop;
            end
            if (mask_wr) mask_q <= mask_data;
        end
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        gsi_stop_fsm u_stop (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_wr  (dma_wr),
            .req_bit (dir_bit[d]),
            .busy    (dir_busy[d]),
            .eof     (dir_eof[d]),
            .done    (dir_done[d])
        );
    end

    always_comb begin
        set_vec = ev_set;
        set_vec[GTSC_BIT] = set_vec[GTSC_BIT] | dir_done[0];
        set_vec[GRSC_BIT] = set_vec[GRSC_BIT] | dir_done[1];
    end

    gsi_event_reg #(
        .EVW       (EVW),
        .TXF_BIT   (TXF_BIT),
        .RXF_BIT   (RXF_BIT),
        .ERR_GROUP (ERR_GROUP)
    ) u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (ev_clr_wr),
        .clr_data (ev_clr_data),
        .mask_q   (mask_q),
        .event_q  (event_q),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx),
        .irq_err  (irq_err)
    );

    gsi_poll_timer #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dma_wr && !dma_wop),
        .wop_q    (wop_q),
        .gts_q    (gts_q),
        .poll_req (poll_req)
    );
endmodule

// File: rtl/gsi_chk.sv
module gsi_chk #(
    parameter int unsigned     EVW       = 32,
    parameter int unsigned     TXF_BIT   = 0,
    parameter int unsigned     RXF_BIT   = 1,
    parameter int unsigned     GRSC_BIT  = 3,
    parameter logic [EVW-1:0]  ERR_GROUP = '0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dma_wr,
    input logic           dma_grs,
    input logic           dma_wop,
    input logic           rx_busy,
    input logic [EVW-1:0] ev_set,
    input logic [EVW-1:0] event_q,
    input logic           irq_tx,
    input logic           irq_rx,
    input logic           irq_err,
    input logic           poll_req
);
    // R7
    irq_tx_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> event_q[TXF_BIT]);

    // R7
    irq_rx_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> event_q[RXF_BIT]);

    // R8
    irq_err_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ((event_q & ERR_GROUP) != '0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((event_q & $past(ev_set)) == $past(ev_set)));

    // R2
    rx_stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && dma_grs && !rx_busy) |=> event_q[GRSC_BIT]);

    // R10
    wop_blocks_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && dma_wop) |=> !poll_req);

    // R9
    poll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req);
endmodule

bind stop_irq_agg gsi_chk #(
    .EVW       (EVW),
    .TXF_BIT   (TXF_BIT),
    .RXF_BIT   (RXF_BIT),
    .GRSC_BIT  (GRSC_BIT),
    .ERR_GROUP (ERR_GROUP)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_wr   (dma_wr),
    .dma_grs  (dma_grs),
    .dma_wop  (dma_wop),
    .rx_busy  (rx_busy),
    .ev_set   (ev_set),
    .event_q  (event_q),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx),
    .irq_err  (irq_err),
    .poll_req (poll_req)
);

// File: tb/stop_irq_agg_tb_top.sv
module stop_irq_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 8;

    typedef struct {
        string       req;
        logic [31:0] ev;
        logic [2:0]  irq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_wr = 0, dma_grs = 0, dma_gts = 0, dma_wop = 0;
    logic        mask_wr = 0, ev_clr_wr = 0;
    logic [31:0] mask_data = '0, ev_clr_data = '0, ev_set = '0;
    logic        tx_busy = 0, rx_busy = 0, tx_eof = 0, rx_eof = 0;
    logic [31:0] event_q;
    logic        irq_tx, irq_rx, irq_err, poll_req;

    int checks = 0;
    int fails = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stop_irq_agg #(.TICK_CYCLES(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dma_wr(dma_wr), .dma_grs(dma_grs), .dma_gts(dma_gts), .dma_wop(dma_wop),
        .mask_wr(mask_wr), .mask_data(mask_data),
        .ev_clr_wr(ev_clr_wr), .ev_clr_data(ev_clr_data), .ev_set(ev_set),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_eof(tx_eof), .rx_eof(rx_eof),
        .event_q(event_q), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
        .poll_req(poll_req)
    );

    // monitor: compares queued expectations against outputs at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (event_q !== it.ev || {irq_tx, irq_rx, irq_err} !== it.irq) begin
                fails++;
                $display("FAIL %s: ev=%h irq=%b expected ev=%h irq=%b",
                         it.req, event_q, {irq_tx, irq_rx, irq_err}, it.ev, it.irq);
            end
        end
    end

    task automatic push(string req, logic [31:0] ev, logic [2:0] irq);
        exp_t it;
        it.req = req; it.ev = ev; it.irq = irq;
        sb_q.push_back(it);
    endtask

    // one cycle of stimulus, then the expected state after the edge
    task automatic cycle_exp(string req, logic [31:0] ev, logic [2:0] irq);
        @(posedge clk); #1;
        dma_wr = 0; mask_wr = 0; ev_clr_wr = 0; ev_set = '0;
        tx_eof = 0; rx_eof = 0;
        push(req, ev, irq);
        @(negedge clk);
    endtask

    task automatic ctrl(logic grs, logic gts, logic wop);
        dma_wr = 1; dma_grs = grs; dma_gts = gts; dma_wop = wop;
    endtask

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_polls(output int n, output int first);
        n = 0; first = -1;
        for (int i = 1; i <= 5 * TICK; i++) begin
            @(negedge clk);
            if (poll_req) begin
                n++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        int n, first;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        push("R1 reset", 32'h0, 3'b000);
        @(negedge clk);
        check_val("R1 no poll after reset", int'(poll_req), 0);

        mask_wr = 1; mask_data = 32'h0000_000F;
        cycle_exp("R1 mask write", 32'h0, 3'b000);
        ctrl(1, 0, 0);
        cycle_exp("R2 rx stop idle", 32'h8, 3'b001);
        ev_clr_wr = 1; ev_clr_data = 32'h8;
        cycle_exp("R8 clear drops err", 32'h0, 3'b000);

        ctrl(0, 1, 0);
        cycle_exp("R3 tx stop idle", 32'h4, 3'b001);
        ev_clr_wr = 1; ev_clr_data = 32'h4;
        cycle_exp("R3 clear", 32'h0, 3'b000);

        mask_wr = 1; mask_data = 32'h0000_0003;
        rx_busy = 1;
        ctrl(1, 0, 0);
        cycle_exp("R4 deferred no event", 32'h0, 3'b000);
        cycle_exp("R4 still waiting", 32'h0, 3'b000);
        rx_eof = 1; rx_busy = 0;
        cycle_exp("R5 eof completes masked", 32'h8, 3'b000);
        ev_clr_wr = 1; ev_clr_data = 32'h8;
        cycle_exp("R6 clear", 32'h0, 3'b000);

        mask_wr = 1; mask_data = 32'hFFFF_FFFF;
        cycle_exp("R8 mask all", 32'h0, 3'b000);
        ev_set = 32'h400;
        cycle_exp("R8 error event raises", 32'h400, 3'b001);
        ev_set = 32'h8;
        cycle_exp("R8 second error event", 32'h408, 3'b001);
        ev_clr_wr = 1; ev_clr_data = 32'h400;
        cycle_exp("R8 err held by remaining", 32'h8, 3'b001);
        ev_clr_wr = 1; ev_clr_data = 32'h8;
        cycle_exp("R8 all clear drops err", 32'h0, 3'b000);

        ev_set = 32'h1;
        cycle_exp("R7 tx irq", 32'h1, 3'b100);
        ev_set = 32'h2;
        cycle_exp("R7 rx irq", 32'h3, 3'b110);
        ev_clr_wr = 1; ev_clr_data = 32'h2;
        cycle_exp("R7 rx drops tx stays", 32'h1, 3'b100);
        ev_clr_wr = 1; ev_clr_data = 32'h1;
        cycle_exp("R7 tx drops", 32'h0, 3'b000);

        ev_set = 32'h4000_0000; ev_clr_wr = 1; ev_clr_data = 32'h4000_0000;
        cycle_exp("R6 set beats clear", 32'h4000_0000, 3'b000);
        ev_clr_wr = 1; ev_clr_data = 32'h4000_0000;
        cycle_exp("R6 clear", 32'h0, 3'b000);

        ctrl(0, 0, 0);
        @(posedge clk); #1; dma_wr = 0;
        count_polls(n, first);
        check_val("R9 first poll cycle", first, TICK);
        check_val("R9 poll count", n, 5);

        ctrl(0, 1, 0);
        @(posedge clk); #1; dma_wr = 0;
        count_polls(n, first);
        check_val("R10 gts blocks poll", n, 0);
        ev_clr_wr = 1; ev_clr_data = 32'h4;
        cycle_exp("R3 clear after gts", 32'h0, 3'b000);

        ctrl(0, 0, 1);
        @(posedge clk); #1; dma_wr = 0;
        count_polls(n, first);
        check_val("R10 wop blocks poll", n, 0);

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule